// File: doc/BRIEF.md
# Serial Bit-Clock Source Selector and Generator

This block sits at the front of a serial audio receiver that runs on a master clock. It decides whether the serial bit clock is supplied from outside on a pin, or must be produced inside by dividing the master clock. It watches that pin for rising edges. A burst of edges inside one half of the frame clock switches the block to the external source. A stretch of two whole frames with no edge switches it back to the internal divider.

In internal mode the divider produces a bit clock whose rate is a fixed multiple of the frame rate. That multiple depends on the selected data format and on the ratio of master clock to frame clock. The divider restarts at every frame-clock transition, so its edges stay aligned to the frame.

The same pin has a second use. While the block is in internal mode the pin carries no clock, so it is read as the upper bit of a de-emphasis selection. The block decodes that selection into a 2-bit code for a downstream filter.

The frame clock is assumed to be synchronous to the master clock. The bit-clock pin and the de-emphasis input are asynchronous and pass through two-flop synchronizers.

Top module: `sckm_mode_ctl`

## Requirements
- R1: `ext_mode` rises once 16 synchronized rising edges of `sck_pin` have been seen within a single phase of `lrck_in`. The edge count clears at every `lrck_in` transition, so 15 edges in each of two consecutive phases leave the block in internal mode.
- R2: In external mode a frame is the interval from one `lrck_in` rising edge to the next. `ext_mode` falls at the frame boundary that ends the second consecutive complete frame with no pin rising edge. A frame in which the pin still rose counts as active.
- R3: In internal mode the number of bit-clock periods per frame is set as follows. The format codes on `fmt_sel` are 00 I2S, 01 left-justified, 10 right-justified 24-bit and 11 right-justified 16-bit. The ratio codes on `mratio_sel` are 0=128, 1=192, 2=256, 3=384, and 4 to 7 = 512 master cycles per frame.
  - 32 periods per frame for formats 00 and 11 with ratio codes 0, 2 and 4 to 7.
  - 64 periods per frame for formats 01 and 10 with those same ratio codes.
  - 48 periods per frame for ratio codes 1 and 3 with any format.
- R4: In internal mode `bclk_rise` pulses for one master cycle once every N master cycles, where N is the master cycles per frame divided by the bit-clock periods per frame. Each `lrck_in` phase therefore holds exactly half the per-frame count of pulses.
- R5: The divider restarts on the master-clock edge that samples an `lrck_in` transition. On the following cycle `bclk_out` is low, and the first `bclk_rise` of the phase follows N/2 cycles after that edge.
- R6: In external mode `bclk_out` follows the synchronized pin. `bclk_rise` gives exactly one pulse per pin rising edge, and the internal divider has no effect on either output.
- R7: In internal mode the pair formed by the synchronized `sck_pin` level (upper bit) and `dem0_in` (lower bit) decodes onto `deemph` as 00 to off (00), 01 to 44.1 kHz (10), 10 to 48 kHz (11), and 11 to 32 kHz (01).
- R8: In external mode only `dem0_in` is decoded: 0 gives off (00) and 1 gives 44.1 kHz (10).
- R9: A synchronous active-low reset puts the block in internal mode with `deemph` = 00, and this holds even while the pin is toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_in | input | 1 | Frame (left/right) clock, synchronous to `clk` |
| sck_pin | input | 1 | Shared pin: external bit clock or upper de-emphasis select |
| dem0_in | input | 1 | Lower de-emphasis select |
| fmt_sel | input | 2 | Serial data format code |
| mratio_sel | input | 3 | Master-to-frame clock ratio code |
| bclk_out | output | 1 | Selected bit clock, as a level in the `clk` domain |
| bclk_rise | output | 1 | One-cycle strobe on each rising edge of the selected bit clock |
| ext_mode | output | 1 | 1 when the external bit clock is in use |
| deemph | output | 2 | De-emphasis code: 00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz |

## Verification
Internal state problems show up at the ports in the following ways:

- A wrong edge count or a missed clear at a frame transition makes `ext_mode` rise one phase early on 15-edge bursts, or not at all on a 16-edge burst. This is visible within one frame-clock phase.
- A faulty idle-frame count moves the fall of `ext_mode` to the wrong frame boundary. The bench checks both the second and the third boundary after the pin stops.
- Divider faults change the number of `bclk_rise` pulses counted in one phase, or the cycle of the first pulse after a frame edge. Either is seen within the first complete phase after a format or ratio change.
- A wrong decode appears on `deemph` three cycles after the select inputs settle.

// File: rtl/sckm_pkg.sv
// Shared types and the divide-ratio decode for the bit-clock mode block.
// Assumes ratio codes 0..4 (128,192,256,384,512); codes 5..7 act as 512.
package sckm_pkg;

    localparam int DIV_W = 5;

    typedef enum logic [1:0] {
        FMT_I2S     = 2'd0,
        FMT_LEFT    = 2'd1,
        FMT_RIGHT24 = 2'd2,
        FMT_RIGHT16 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        DE_OFF = 2'd0,
        DE_32K = 2'd1,
        DE_44K = 2'd2,
        DE_48K = 2'd3
    } deemph_e;

    // Master cycles per bit-clock period for a format and ratio code.
    function automatic logic [DIV_W-1:0] div_factor(input logic [1:0] fmt,
                                                     input logic [2:0] mr);
        logic wide;
        wide = (fmt == FMT_LEFT) || (fmt == FMT_RIGHT24);
        case (mr)
            3'd0:    div_factor = wide ? DIV_W'(2) : DIV_W'(4);
            3'd1:    div_factor = DIV_W'(4);
            3'd2:    div_factor = wide ? DIV_W'(4) : DIV_W'(8);
            3'd3:    div_factor = DIV_W'(8);
            default: div_factor = wide ? DIV_W'(8) : DIV_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/sckm_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent quasi-static or slow level.
module sckm_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] level
);
    logic [W-1:0] chain [STAGES];

    // Shift each pin through STAGES flops; reset clears the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= pin;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/sckm_mode_detect.sv
// Decides between the external and internal bit-clock source.
// Counts synchronized pin rising edges per frame-clock phase to enter
// external mode, and counts edge-free frames to leave it.
// Assumes lrck_edge/frame_start are one-cycle strobes in the clk domain.
module sckm_mode_detect #(
    parameter int EDGE_THR     = 16,
    parameter int QUIET_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_lvl,
    input  logic lrck_edge,
    input  logic frame_start,
    output logic pin_rise,
    output logic ext_mode
);
    localparam int ECNT_W = $clog2(EDGE_THR + 1);
    localparam int QCNT_W = $clog2(QUIET_FRAMES + 1);
    localparam logic [ECNT_W-1:0] THR_V = ECNT_W'(EDGE_THR);
    localparam logic [QCNT_W-1:0] QLAST = QCNT_W'(QUIET_FRAMES - 1);

    logic              sck_d;
    logic              hit;
    logic [ECNT_W-1:0] ecnt, ecnt_base, ecnt_nx;
    logic [QCNT_W-1:0] qcnt;

    assign pin_rise = sck_lvl & ~sck_d;

    // Next edge count: restart at each phase, saturate at threshold.
    always_comb begin
        ecnt_base = lrck_edge ? '0 : ecnt;
        ecnt_nx   = (pin_rise && ecnt_base != THR_V) ? ecnt_base + 1'b1 : ecnt_base;
    end

    // Edge history and per-phase edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            ecnt  <= '0;
        end else begin
            sck_d <= sck_lvl;
            ecnt  <= ecnt_nx;
        end
    end

    // Per-frame activity flag and consecutive quiet-frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit  <= 1'b0;
            qcnt <= '0;
        end else begin
            hit <= frame_start ? pin_rise : (hit | pin_rise);
            if (!ext_mode || (frame_start && (hit || pin_rise)))
                qcnt <= '0;
            else if (frame_start && qcnt != QLAST)
                qcnt <= qcnt + 1'b1;
        end
    end

    // Mode flag: enter on threshold, leave after enough quiet frames.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_mode <= 1'b0;
        else if (!ext_mode && ecnt_nx == THR_V)
            ext_mode <= 1'b1;
        else if (ext_mode && frame_start && !hit && !pin_rise && qcnt == QLAST)
            ext_mode <= 1'b0;
    end

    // R1: entry into external mode needs a pin edge in the cycle before.
    a_r1_enter_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_mode) |-> $past(pin_rise));
    // R2: leaving external mode only happens at a frame boundary.
    a_r2_leave_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_mode) |-> $past(frame_start));
    // R2: a pin edge while external keeps the block external next cycle.
    a_r2_rise_keeps_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && pin_rise) |=> ext_mode);
endmodule

// File: rtl/sckm_div_gen.sv
// Internal bit-clock divider: divides clk by div and restarts at every
// frame-clock transition so bit-clock edges align to the frame.
// Assumes div >= 2 and even.
module sckm_div_gen #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck_edge,
    input  logic [CNT_W-1:0] div,
    output logic             bclk,
    output logic             bclk_rise
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    assign half = div >> 1;

    // Phase counter: cleared at frame edges, wraps at div-1.
    always_ff @(posedge clk) begin
        if (!rst_n || lrck_edge)
            cnt <= '0;
        else if (cnt >= div - 1'b1)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign bclk      = (cnt >= half);
    assign bclk_rise = (cnt == half);

    // R5: bit clock is low on the cycle after a frame-clock transition.
    a_r5_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        lrck_edge |=> !bclk);
    // R4: rise strobes never occur on adjacent cycles.
    a_r4_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |=> !bclk_rise);
endmodule

// File: rtl/sckm_deemph_dec.sv
// Decodes the de-emphasis selection; the upper select bit is the shared
// bit-clock pin and is honoured only in internal mode.
module sckm_deemph_dec (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_mode,
    input  logic       sel_hi,
    input  logic       sel_lo,
    output logic [1:0] code
);
    import sckm_pkg::*;

    deemph_e code_nx, code_q;

    // Select decode by mode.
    always_comb begin
        if (ext_mode)
            code_nx = sel_lo ? DE_44K : DE_OFF;
        else begin
            case ({sel_hi, sel_lo})
                2'b00:   code_nx = DE_OFF;
                2'b01:   code_nx = DE_44K;
                2'b10:   code_nx = DE_48K;
                default: code_nx = DE_32K;
            endcase
        end
    end

    // Registered output code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= DE_OFF;
        else        code_q <= code_nx;
    end

    assign code = code_q;

    // R8: after a cycle in external mode only off or 44.1 kHz can appear.
    a_r8_ext_limited: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ext_mode) |-> (code_q == DE_OFF || code_q == DE_44K));
endmodule

// File: rtl/sckm_mode_ctl.sv
// Top: bit-clock source selection, internal generation and de-emphasis
// decode. Assumes lrck_in is synchronous to clk; sck_pin and dem0_in are
// asynchronous and are synchronized here.
module sckm_mode_ctl #(
    parameter int EDGE_THR     = 16,
    parameter int QUIET_FRAMES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck_in,
    input  logic       sck_pin,
    input  logic       dem0_in,
    input  logic [1:0] fmt_sel,
    input  logic [2:0] mratio_sel,
    output logic       bclk_out,
    output logic       bclk_rise,
    output logic       ext_mode,
    output logic [1:0] deemph
);
    import sckm_pkg::*;

    localparam int CNT_W = DIV_W;

    logic             lrck_q, lrck_edge, frame_start;
    logic [1:0]       sync_lvl;
    logic             pin_rise, gen_bclk, gen_rise;
    logic [CNT_W-1:0] div;

    // Frame-clock history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lrck_q <= 1'b0;
        else        lrck_q <= lrck_in;
    end

    assign lrck_edge   = lrck_in ^ lrck_q;
    assign frame_start = lrck_in & ~lrck_q;
    assign div         = div_factor(fmt_sel, mratio_sel);

    sckm_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin({dem0_in, sck_pin}), .level(sync_lvl));

    sckm_mode_detect #(.EDGE_THR(EDGE_THR), .QUIET_FRAMES(QUIET_FRAMES)) u_detect (
        .clk(clk), .rst_n(rst_n), .sck_lvl(sync_lvl[0]), .lrck_edge(lrck_edge),
        .frame_start(frame_start), .pin_rise(pin_rise), .ext_mode(ext_mode));

    sckm_div_gen #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .lrck_edge(lrck_edge), .div(div),
        .bclk(gen_bclk), .bclk_rise(gen_rise));

    sckm_deemph_dec u_deemph (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sel_hi(sync_lvl[0]),
        .sel_lo(sync_lvl[1]), .code(deemph));

    assign bclk_out  = ext_mode ? sync_lvl[0] : gen_bclk;
    assign bclk_rise = ext_mode ? pin_rise    : gen_rise;

    // R9: the cycle after reset is sampled low, the block is internal.
    a_r9_reset_internal: assert property (@(posedge clk)
        !$past(rst_n) |-> (!ext_mode && deemph == 2'b00));
endmodule

// File: tb/test_sckm_mode_ctl.sv
module test_sckm_mode_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck = 1'b0;
    logic       sck = 1'b0;
    logic       dem0 = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic [2:0] mr = 3'd2;
    logic       bclk_out, bclk_rise, ext_mode;
    logic [1:0] deemph;

    int  checks = 0;
    int  fails = 0;
    int  half_len = 128;
    bit  sck_run = 0;
    bit  dem1_lvl = 0;
    int  burst_left = 0;

    sckm_mode_ctl i_sckm_mode_ctl (
        .clk(clk), .rst_n(rst_n), .lrck_in(lrck), .sck_pin(sck), .dem0_in(dem0),
        .fmt_sel(fmt), .mratio_sel(mr), .bclk_out(bclk_out), .bclk_rise(bclk_rise),
        .ext_mode(ext_mode), .deemph(deemph));

    always #4 clk = ~clk;

    // Frame clock: toggles every half_len master cycles.
    initial forever begin
        repeat (half_len) @(posedge clk);
        #1 lrck = ~lrck;
    end

    // Pin driver: free-running clock, counted bursts, or a static level.
    initial forever begin
        repeat (2) @(posedge clk);
        #1;
        if (sck_run) sck = ~sck;
        else if (burst_left > 0) begin
            if (sck) sck = 1'b0;
            else begin sck = 1'b1; burst_left--; end
        end else sck = dem1_lvl;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // R3 R4 R5: count rises in a full phase, and where the first falls.
    task automatic t_rate(input logic [1:0] f, input logic [2:0] code,
                          input int mpf, input int bits);
        int n, first, idx, nd;
        bit sv;
        fmt = f; mr = code; half_len = mpf / 2;
        nd = mpf / bits;
        repeat (3) @(lrck);
        sv = lrck; n = 0; first = -1; idx = 0;
        while (lrck == sv) begin
            @(negedge clk);
            if (lrck == sv && bclk_rise) begin
                n++;
                if (first < 0) first = idx;
            end
            idx++;
        end
        check($sformatf("R3/R4 rises per phase fmt=%0d ratio=%0d", f, code), n, bits / 2);
        if (nd >= 4)
            check($sformatf("R5 first rise position fmt=%0d ratio=%0d", f, code),
                  first, nd / 2 + 1);
        check("R3 internal mode held", ext_mode, 0);
    endtask

    // R1: 15 edges per phase twice stays internal; 16 in a phase enters.
    task automatic t_enter();
        fmt = 2'd0; mr = 3'd2; half_len = 128;
        repeat (3) @(lrck);
        burst_left = 15;
        @(lrck);
        burst_left = 15;
        @(lrck);
        repeat (4) @(negedge clk);
        check("R1 two 15-edge phases stay internal", ext_mode, 0);
        @(lrck);
        burst_left = 16;
        repeat (16 * 4 + 10) @(negedge clk);
        check("R1 16 edges in one phase enter external", ext_mode, 1);
    endtask

    // R6: in external mode, one rise strobe per pin edge.
    task automatic t_ext_follow();
        int n = 0;
        sck_run = 1;
        repeat (20) @(negedge clk);
        sck_run = 0;
        repeat (6) @(negedge clk);
        fork
            burst_left = 20;
            begin
                repeat (100) begin
                    @(negedge clk);
                    if (bclk_rise) n++;
                end
            end
        join
        check("R6 strobes follow pin edges", n, 20);
        check("R6 still external", ext_mode, 1);
        sck_run = 1;
    endtask

    // R8: external-mode de-emphasis uses only the lower select.
    task automatic t_deemph_ext();
        dem0 = 1'b0;
        repeat (8) @(negedge clk);
        check("R8 external dem0=0 off", deemph, 0);
        dem0 = 1'b1;
        repeat (8) @(negedge clk);
        check("R8 external dem0=1 44.1k", deemph, 2);
        dem0 = 1'b0;
    endtask

    // R2: fall back after two complete edge-free frames.
    task automatic t_fallback();
        @(posedge lrck);
        repeat (20) @(negedge clk);
        sck_run = 0;
        @(posedge lrck);
        repeat (3) @(negedge clk);
        check("R2 active frame keeps external", ext_mode, 1);
        @(posedge lrck);
        repeat (3) @(negedge clk);
        check("R2 one quiet frame keeps external", ext_mode, 1);
        @(posedge lrck);
        repeat (3) @(negedge clk);
        check("R2 two quiet frames return internal", ext_mode, 0);
    endtask

    // R7: internal-mode decode of {pin, dem0}.
    task automatic t_deemph_int();
        int exp_code [4] = '{0, 2, 3, 1};
        for (int k = 0; k < 4; k++) begin
            dem1_lvl = k[1];
            dem0 = k[0];
            repeat (8) @(negedge clk);
            check($sformatf("R7 internal select %0d", k), deemph, exp_code[k]);
        end
        dem1_lvl = 0; dem0 = 0;
        repeat (8) @(negedge clk);
        check("R7 pin level change leaves mode internal", ext_mode, 0);
    endtask

    // R9: reset while external returns to internal.
    task automatic t_reset_mid();
        dem0 = 1'b1;
        sck_run = 1;
        repeat (300) @(negedge clk);
        check("R9 precondition external", ext_mode, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 reset forces internal", ext_mode, 0);
        check("R9 reset clears deemph", deemph, 0);
        sck_run = 0;
        dem0 = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R9 reset state external flag", ext_mode, 0);
        check("R9 reset state deemph", deemph, 0);
        rst_n = 1'b1;
        t_rate(2'd0, 3'd4, 512, 32);
        t_rate(2'd1, 3'd2, 256, 64);
        t_rate(2'd3, 3'd0, 128, 32);
        t_rate(2'd2, 3'd0, 128, 64);
        t_rate(2'd0, 3'd3, 384, 48);
        t_rate(2'd1, 3'd1, 192, 48);
        t_enter();
        t_ext_follow();
        t_deemph_ext();
        t_fallback();
        t_deemph_int();
        t_reset_mid();
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule